// File: doc/BRIEF.md
# Burst Transmit Framer with Scrambler and AMI Encoder

This block builds one downstream burst for a ping-pong two-wire subscriber line. Each burst carries two B channels and a D channel. A system-side controller presents a 36-bit payload and a mode, then pulses `burst_start` once per burst repetition period (250 us). The block puts an unscrambled framing bit in front of the payload and scrambles the B and D bits with a self-synchronising x^9 + x^5 + 1 scrambler. It then shifts out the 37 bits at the in-burst rate (384 kbit/s, one bit every `CLKS_PER_BIT` clocks) as alternate-mark-inversion symbols on a positive/negative pulse pair.

The mode picks what goes on the line. It can be scrambled user data (the active info), scrambled all-ones (the training info) or silence (no signal). The scrambler state and the AMI polarity both carry over from one burst to the next, so the far-end descrambler and the line's DC balance see one continuous stream. Silent bursts and idle gaps between bursts leave both states untouched.

Top module: `burst_framer_tx`

## Requirements
- R1: When `burst_start` is high at a clock edge while `busy` is low, `busy` goes high from the next cycle. It stays high for exactly 37 x `CLKS_PER_BIT` cycles, and each frame bit is held for `CLKS_PER_BIT` cycles.
- R2: A `burst_start` that arrives while `busy` is high is ignored. The running burst keeps its length and its content.
- R3: The first bit of every non-silent burst is the framing bit, sent as logical 1 and never scrambled. Payload bits `payload[35]` down to `payload[0]` follow in that order. The payload is packed as {B1, B2, D, B1, B2, D}, with each octet MSB first.
- R4: Each B/D bit is scrambled as s = d XOR q[4] XOR q[8], where q is a 9-bit history that shifts s in at q[0]. The history resets to zero, advances only on B/D bits of non-silent bursts, and keeps its value between bursts.
- R5: Mode encoding, sampled at the accepted `burst_start`: 2'b10 sends the payload, 2'b01 sends ones in every B/D position (training), 2'b00 is silent, and 2'b11 behaves as silent.
- R6: A line bit of 1 is a pulse whose polarity is opposite to the previous pulse (`line_pos` or `line_neg` high for that bit period), and a 0 is neutral. The first pulse after reset is positive, the polarity carries across bursts, and the two outputs are never high together.
- R7: A silent burst keeps both outputs low for its whole length, and it changes neither the scrambler history nor the AMI polarity.
- R8: While `busy` is low, `line_pos` and `line_neg` are low.
- R9: Changes to `mode` or `payload` after a burst has been accepted do not affect that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| burst_start | input | 1 | Starts a burst when the block is idle |
| mode | input | 2 | Line content selector (R5) |
| payload | input | 36 | B1,B2,D,B1,B2,D user bits in transmit order |
| busy | output | 1 | High during the 37 bit periods of a burst |
| line_pos | output | 1 | Positive AMI pulse to the line driver |
| line_neg | output | 1 | Negative AMI pulse to the line driver |

## Verification
Two events can fall on the same clock edge. The end of one burst, where the last bit commits the final polarity and scrambler update, can coincide with the acceptance of the next burst. The bench provokes this by raising `burst_start` during the final bits of a burst and holding it high. That start must be ignored while `busy` is high and then accepted on the first idle edge. The follow-on burst is judged by checking that its framing pulse has the polarity opposite to the last pulse of the previous burst, and that its descrambled B/D bits match with no resynchronisation gap. A second overlap, a start request or a payload/mode change arriving mid-burst, is checked against an undisturbed model of the burst.

// File: rtl/burst_framer_pkg.sv
package burst_framer_pkg;
   typedef enum logic [1:0] {
      MODE_SILENT = 2'b00,
      MODE_TRAIN  = 2'b01,
      MODE_DATA   = 2'b10,
      MODE_RSVD   = 2'b11
   } bf_mode_e;

   function automatic logic mode_emits(input logic [1:0] m);
      return (m == MODE_TRAIN) || (m == MODE_DATA);
   endfunction
endpackage

// File: rtl/bf_bit_timer.sv
module bf_bit_timer #(
   parameter int FRAME_BITS   = 37,
   parameter int CLKS_PER_BIT = 4,
   localparam int IDX_W       = $clog2(FRAME_BITS),
   localparam int DIV_W       = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   output logic             load,
   output logic             busy,
   output logic             bit_end,
   output logic [IDX_W-1:0] bit_idx
);
   logic             busy_q;
   logic [IDX_W-1:0] idx_q;

   generate
      if (FRAME_BITS < 2) begin : g_bad_frame
         $error("bf_bit_timer: FRAME_BITS must be at least 2");
      end
      if (CLKS_PER_BIT < 1) begin : g_bad_div
         $error("bf_bit_timer: CLKS_PER_BIT must be at least 1");
      end
   endgenerate

   assign load = start & ~busy_q;

   generate
      if (CLKS_PER_BIT == 1) begin : g_nodiv
         assign bit_end = busy_q;
      end else begin : g_div
         logic [DIV_W-1:0] div_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               div_q <= '0;
            end else if (load) begin
               div_q <= '0;
            end else if (busy_q) begin
               if (div_q == DIV_W'(CLKS_PER_BIT - 1)) div_q <= '0;
               else                                   div_q <= div_q + 1'b1;
            end
         end
         assign bit_end = busy_q && (div_q == DIV_W'(CLKS_PER_BIT - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         idx_q  <= '0;
      end else if (load) begin
         busy_q <= 1'b1;
         idx_q  <= '0;
      end else if (bit_end) begin
         if (idx_q == IDX_W'(FRAME_BITS - 1)) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
         end else begin
            idx_q <= idx_q + 1'b1;
         end
      end
   end

   assign busy    = busy_q;
   assign bit_idx = idx_q;
endmodule

// File: rtl/bf_frame_src.sv
module bf_frame_src
   import burst_framer_pkg::*;
#(
   parameter int PAYLOAD_BITS = 36
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    load,
   input  logic                    advance,
   input  logic [1:0]              mode_in,
   input  logic [PAYLOAD_BITS-1:0] payload_in,
   output logic                    emits,
   output logic                    user_bit
);
   logic [PAYLOAD_BITS-1:0] sr_q;
   bf_mode_e                mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q   <= '0;
         mode_q <= MODE_SILENT;
      end else if (load) begin
         sr_q   <= payload_in;
         mode_q <= bf_mode_e'(mode_in);
      end else if (advance) begin
         sr_q <= {sr_q[PAYLOAD_BITS-2:0], 1'b0};
      end
   end

   assign emits    = mode_emits(mode_q);
   assign user_bit = (mode_q == MODE_DATA) ? sr_q[PAYLOAD_BITS-1] : 1'b1;
endmodule

// File: rtl/bf_scrambler.sv
module bf_scrambler #(
   parameter int LEN    = 9,
   parameter int TAP    = 5,
   parameter bit ENABLE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic step,
   input  logic din,
   output logic dout
);
   generate
      if (TAP < 1 || TAP >= LEN) begin : g_bad_tap
         $error("bf_scrambler: TAP must lie in 1..LEN-1");
      end

      if (ENABLE) begin : g_scr
         logic [LEN-1:0] hist_q;
         assign dout = din ^ hist_q[TAP-1] ^ hist_q[LEN-1];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    hist_q <= '0;
            else if (step) hist_q <= {hist_q[LEN-2:0], dout};
         end
      end else begin : g_bypass
         logic unused_ok;
         assign unused_ok = clk ^ rst_n ^ step;
         assign dout      = din;
      end
   endgenerate
endmodule

// File: rtl/bf_ami_encoder.sv
module bf_ami_encoder (
   input  logic clk,
   input  logic rst_n,
   input  logic valid,
   input  logic step,
   input  logic bit_in,
   output logic pos,
   output logic neg
);
   logic next_pos_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  next_pos_q <= 1'b1;
      else if (step && bit_in)     next_pos_q <= ~next_pos_q;
   end

   assign pos = valid & bit_in &  next_pos_q;
   assign neg = valid & bit_in & ~next_pos_q;
endmodule

// File: rtl/burst_framer_tx.sv
module burst_framer_tx #(
   parameter int B_BITS       = 8,
   parameter int D_BITS       = 2,
   parameter int HALVES       = 2,
   parameter int CLKS_PER_BIT = 4,
   parameter int SCR_LEN      = 9,
   parameter int SCR_TAP      = 5,
   parameter bit SCRAMBLE_EN  = 1'b1,
   localparam int PAYLOAD_BITS = HALVES * (2 * B_BITS + D_BITS),
   localparam int FRAME_BITS   = PAYLOAD_BITS + 1,
   localparam int IDX_W        = $clog2(FRAME_BITS)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    burst_start,
   input  logic [1:0]              mode,
   input  logic [PAYLOAD_BITS-1:0] payload,
   output logic                    busy,
   output logic                    line_pos,
   output logic                    line_neg
);
   logic             load;
   logic             bit_end;
   logic [IDX_W-1:0] bit_idx;
   logic             emits;
   logic             user_bit;
   logic             scr_bit;
   logic             is_frame;
   logic             line_bit;

   generate
      if (HALVES < 1 || B_BITS < 1 || D_BITS < 1) begin : g_bad_shape
         $error("burst_framer_tx: frame shape parameters must be positive");
      end
   endgenerate

   bf_bit_timer #(
      .FRAME_BITS  (FRAME_BITS),
      .CLKS_PER_BIT(CLKS_PER_BIT)
   ) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (burst_start),
      .load   (load),
      .busy   (busy),
      .bit_end(bit_end),
      .bit_idx(bit_idx)
   );

   assign is_frame = (bit_idx == '0);

   bf_frame_src #(
      .PAYLOAD_BITS(PAYLOAD_BITS)
   ) u_src (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .advance   (bit_end & ~is_frame),
      .mode_in   (mode),
      .payload_in(payload),
      .emits     (emits),
      .user_bit  (user_bit)
   );

   bf_scrambler #(
      .LEN   (SCR_LEN),
      .TAP   (SCR_TAP),
      .ENABLE(SCRAMBLE_EN)
   ) u_scr (
      .clk  (clk),
      .rst_n(rst_n),
      .step (bit_end & ~is_frame & emits),
      .din  (user_bit),
      .dout (scr_bit)
   );

   assign line_bit = emits & (is_frame | scr_bit);

   bf_ami_encoder u_ami (
      .clk   (clk),
      .rst_n (rst_n),
      .valid (busy),
      .step  (bit_end),
      .bit_in(line_bit),
      .pos   (line_pos),
      .neg   (line_neg)
   );
endmodule

// File: rtl/bf_checker.sv
module bf_checker #(
   parameter int FRAME_BITS   = 37,
   parameter int CLKS_PER_BIT = 4,
   localparam int TOTAL       = FRAME_BITS * CLKS_PER_BIT,
   localparam int CNT_W       = $clog2(TOTAL + 1)
) (
   input logic       clk,
   input logic       rst_n,
   input logic       burst_start,
   input logic [1:0] mode,
   input logic       busy,
   input logic       line_pos,
   input logic       line_neg
);
   logic [CNT_W-1:0] run_cnt;
   logic             pos_d, neg_d, last_pos;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    run_cnt <= '0;
      else if (busy) run_cnt <= run_cnt + 1'b1;
      else           run_cnt <= '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_d    <= 1'b0;
         neg_d    <= 1'b0;
         last_pos <= 1'b0;
      end else begin
         pos_d <= line_pos;
         neg_d <= line_neg;
         if (line_pos && !pos_d)      last_pos <= 1'b1;
         else if (line_neg && !neg_d) last_pos <= 1'b0;
      end
   end

   assert_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (burst_start && !busy) |=> busy);

   assert_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (run_cnt == CNT_W'(TOTAL)));

   assert_cap_R1: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (run_cnt < CNT_W'(TOTAL)));

   assert_ignore_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && burst_start && run_cnt < CNT_W'(TOTAL - 1)) |=> busy);

   assert_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ((line_pos || line_neg) ==
                       ($past(mode) == 2'b01 || $past(mode) == 2'b10)));

   assert_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(line_pos && line_neg));

   assert_alt_pos_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (line_pos && !pos_d) |-> !last_pos);

   assert_alt_neg_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (line_neg && !neg_d) |-> last_pos);

   assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!line_pos && !line_neg));
endmodule

bind burst_framer_tx bf_checker #(
   .FRAME_BITS  (FRAME_BITS),
   .CLKS_PER_BIT(CLKS_PER_BIT)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .burst_start(burst_start),
   .mode       (mode),
   .busy       (busy),
   .line_pos   (line_pos),
   .line_neg   (line_neg)
);

// File: tb/burst_framer_tx_tb.sv
module burst_framer_tx_tb;
   localparam int CLK_PERIOD = 10;
   localparam int CPB        = 4;
   localparam int NBITS      = 37;
   localparam int NVEC       = 6;

   localparam logic [37:0] VEC [NVEC] = '{
      {2'b10, 36'h9A5C30F1E},
      {2'b01, 36'h000000000},
      {2'b00, 36'hFFFFFFFFF},
      {2'b10, 36'h000000000},
      {2'b11, 36'h123456789},
      {2'b10, 36'hFFFFFFFFF}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        burst_start = 1'b0;
   logic [1:0]  mode = 2'b00;
   logic [35:0] payload = '0;
   logic        busy, line_pos, line_neg;

   int checks = 0;
   int errors = 0;

   logic [8:0] mscr = '0;   // transmit scrambler model
   logic [8:0] dscr = '0;   // receive descrambler
   logic       mpol = 1'b1; // 1: next pulse positive

   always #(CLK_PERIOD/2) clk = ~clk;

   burst_framer_tx #(.CLKS_PER_BIT(CPB)) u_dut (
      .clk(clk), .rst_n(rst_n), .burst_start(burst_start), .mode(mode),
      .payload(payload), .busy(busy), .line_pos(line_pos), .line_neg(line_neg)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic model_reset();
      mscr = '0;
      dscr = '0;
      mpol = 1'b1;
   endtask

   task automatic run_burst(input logic [37:0] v, input bit disturb, input bit chain_next);
      logic [1:0]  m;
      logic [35:0] p;
      logic        active, d, s, e, r, dd;
      string       tag;
      m = v[37:36];
      p = v[35:0];
      mode    = m;
      payload = p;
      if (!burst_start) begin
         @(negedge clk);
         burst_start = 1'b1;
      end
      @(negedge clk);
      burst_start = 1'b0;
      active = (m == 2'b01) || (m == 2'b10);
      for (int k = 0; k < NBITS; k++) begin
         d = 1'b0;
         if (!active)        e = 1'b0;
         else if (k == 0)    e = 1'b1;
         else begin
            d = (m == 2'b10) ? p[36-k] : 1'b1;
            s = d ^ mscr[4] ^ mscr[8];
            mscr = {mscr[7:0], s};
            e = s;
         end
         if (k == 0)                   tag = "R3";
         else if (disturb && k > 12)   tag = "R9";
         else if (m == 2'b00)          tag = "R7";
         else if (m != 2'b10)          tag = "R5";
         else                          tag = "R6";
         chk(busy == 1'b1, disturb ? "R2" : "R1", 64'(busy), 64'd1);
         chk({line_pos, line_neg} == {e & mpol, e & ~mpol}, tag,
             64'({line_pos, line_neg}), 64'({e & mpol, e & ~mpol}));
         if (e) mpol = ~mpol;
         if (active && k > 0) begin
            r  = line_pos | line_neg;
            dd = r ^ dscr[4] ^ dscr[8];
            dscr = {dscr[7:0], r};
            chk(dd == d, "R4", 64'(dd), 64'(d));
         end
         if (disturb && k == 12) begin
            burst_start = 1'b1;
            mode        = ~m;
            payload     = ~p;
         end
         if (disturb && k == 14) burst_start = 1'b0;
         if (chain_next && k == 34) burst_start = 1'b1;
         repeat (CPB) @(negedge clk);
      end
      chk(busy == 1'b0, "R1", 64'(busy), 64'd0);
      chk({line_pos, line_neg} == 2'b00, "R8", 64'({line_pos, line_neg}), 64'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      // reset state (R8)
      repeat (3) @(negedge clk);
      chk({busy, line_pos, line_neg} == 3'b000, "R8",
          64'({busy, line_pos, line_neg}), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk({busy, line_pos, line_neg} == 3'b000, "R8",
          64'({busy, line_pos, line_neg}), 64'd0);

      // table walk: data, training, silent, zeros, reserved mode, all ones
      for (int i = 0; i < NVEC; i++) begin
         run_burst(VEC[i], 1'b0, 1'b0);
         repeat (7) @(negedge clk);
         chk({line_pos, line_neg} == 2'b00, "R8", 64'({line_pos, line_neg}), 64'd0);
      end

      // start and input changes during a burst (R2, R9)
      run_burst({2'b10, 36'h5A5A5A5A5}, 1'b1, 1'b0);

      // back-to-back: start held across the end of a burst (R1, R6)
      run_burst({2'b10, 36'hC3C3C3C3C}, 1'b0, 1'b1);
      run_burst({2'b01, 36'h0}, 1'b0, 1'b0);

      // reset restores positive first pulse and zero history (R6, R4)
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      model_reset();
      rst_n = 1'b1;
      run_burst({2'b10, 36'h0F0F0F0F0}, 1'b0, 1'b0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule